// File: doc/BRIEF.md
# Row-Parallel Refresh Characteristic Accumulator

This block builds a compact test characteristic of a dynamic memory while periodic refresh is running. Each bit of the memory has an address made of a row part and a column part. The characteristic of the memory is the bitwise XOR of the addresses of every bit that holds a 1. A refresh slot puts one whole row into the row register. The block then reduces that row to its row characteristic in one combinational step, with no bit-serial scan, and folds the result into a running accumulator.

Refresh control raises a pass-start strobe to clear the accumulator before the first row. It raises a row-valid strobe for each row it refreshes. With the final row, or after it, it raises an end-of-pass strobe. On that strobe the block compares the accumulated value with a reference characteristic supplied from outside. A difference sets a sticky mismatch flag, and a done pulse follows. An optional constant-1 tag bit extends every address, so that the bit at row 0, column 0 still adds to the characteristic.

Word-oriented memories need no other mechanism. The column index is the word index with the bit-within-word index joined below it, so the bit position in the row vector is the column address.

Top module: `refresh_char_acc`

## Requirements
- R1: After reset, test_char is 0, mismatch is 0 and done is 0.
- R2: The column field of a row characteristic, test_char bits [COL_AW-1:0], is the XOR of the indices of the row_data bits that are 1.
- R3: The row field, bits [COL_AW+ROW_AW-1:COL_AW], equals row_addr when row_data holds an odd number of 1s and is zero otherwise.
- R4: With TAG_BIT=1, the top bit of the characteristic is the parity of the 1s in the row, so a lone 1 at row 0, column 0 gives a nonzero characteristic.
- R5: A clock edge with row_valid high XORs the row characteristic into test_char, and the new value is visible after that edge. An edge with neither row_valid nor pass_start high leaves test_char unchanged.
- R6: pass_start clears the accumulator at the edge. If row_valid is high in the same cycle, test_char becomes that row's characteristic alone.
- R7: At an edge with pass_end high, the block compares the accumulated value, including any row folded in the same cycle, with ref_char. If they differ, mismatch is 1 after that edge.
- R8: done is 1 during exactly the one cycle after each edge with pass_end high, and 0 otherwise.
- R9: mismatch stays 1 until an edge with clr_mismatch high, and a later matching pass does not clear it. When a mismatching compare and clr_mismatch fall on the same edge, mismatch is 1.
- R10: A row whose data is all zero leaves test_char unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pass_start | input | 1 | Clears the accumulator for a new refresh pass |
| row_valid | input | 1 | The row register holds a refreshed row this cycle |
| row_addr | input | ROW_AW | Address of the row being refreshed |
| row_data | input | NUM_COLS | Full contents of the row register |
| pass_end | input | 1 | Compare the accumulated value with the reference |
| ref_char | input | CW | Reference characteristic |
| clr_mismatch | input | 1 | Clears the sticky mismatch flag |
| test_char | output | CW | Running test characteristic |
| mismatch | output | 1 | Sticky compare-failure flag |
| done | output | 1 | One-cycle pulse after a compare |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge. Each sample therefore sees the state after exactly one rising edge. That single edge is the latency of every result here. test_char reflects a folded row, a clear or a hold one edge after the strobe. mismatch and done reflect an end-of-pass compare one edge after pass_end. done is sampled once more a cycle later to confirm that it has fallen. Row characteristics from the stimulus table are checked against hand-computed values and against an address-sum model that the bench computes on its own.

// File: rtl/rca_pkg.sv
package rca_pkg;
   // Width of a full characteristic: optional tag bit, row field, column field.
   function automatic int char_width(input int row_aw, input int col_aw, input int tag_bit);
      return row_aw + col_aw + tag_bit;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/rca_row_char.sv
module rca_row_char #(
   parameter int ROW_AW   = 4,
   parameter int NUM_COLS = 16,
   parameter int TAG_BIT  = 1,
   localparam int COL_AW  = $clog2(NUM_COLS),
   localparam int CW      = rca_pkg::char_width(ROW_AW, COL_AW, TAG_BIT)
) (
   input  logic [ROW_AW-1:0]   row_addr,
   input  logic [NUM_COLS-1:0] row_data,
   output logic [CW-1:0]       row_char,
   output logic                row_parity
);
   logic [COL_AW-1:0] col_x;
   logic [ROW_AW-1:0] row_f;

   // Column field: bit b is the parity of the ones at columns whose index has bit b set.
   for (genvar b = 0; b < COL_AW; b++) begin : g_colbit
      logic [NUM_COLS-1:0] sel;
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_sel
         if (((c >> b) & 1) == 1) begin : g_on
            assign sel[c] = row_data[c];
         end else begin : g_off
            assign sel[c] = 1'b0;
         end
      end
      assign col_x[b] = ^sel;
   end

   assign row_parity = ^row_data;
   assign row_f      = row_parity ? row_addr : '0;

   if (TAG_BIT == 1) begin : g_tag
      assign row_char = {row_parity, row_f, col_x};
   end else begin : g_notag
      assign row_char = {row_f, col_x};
   end
endmodule

// File: rtl/rca_accum.sv
module rca_accum #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fold,
   input  logic [CW-1:0] row_char,
   output logic [CW-1:0] acc,
   output logic [CW-1:0] acc_next
);
   logic [CW-1:0] base;

   always_comb begin
      base     = clr ? '0 : acc;
      acc_next = fold ? (base ^ row_char) : base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc_next;
   end

   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fold) |=> (acc == '0)); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !fold) |=> $stable(acc)); // R5
   AST_FOLD_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && fold) |=> (acc == ($past(acc) ^ $past(row_char)))); // R5
endmodule

// File: rtl/rca_pass_check.sv
module rca_pass_check #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pass_end,
   input  logic          clr_mismatch,
   input  logic [CW-1:0] final_char,
   input  logic [CW-1:0] ref_char,
   output logic          mismatch,
   output logic          done
);
   logic differ;
   assign differ = (final_char != ref_char);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mismatch <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= pass_end;
         if (pass_end && differ) mismatch <= 1'b1;
         else if (clr_mismatch)  mismatch <= 1'b0;
      end
   end

   AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      pass_end |=> done); // R8
   AST_DONE_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_end |=> !done); // R8
   AST_MISMATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && (final_char != ref_char)) |=> mismatch); // R7
   AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mismatch && !clr_mismatch) |=> mismatch); // R9
endmodule

// File: rtl/refresh_char_acc.sv
module refresh_char_acc #(
   parameter int ROW_AW   = 4,
   parameter int NUM_COLS = 16,
   parameter int TAG_BIT  = 1,
   localparam int COL_AW  = $clog2(NUM_COLS),
   localparam int CW      = rca_pkg::char_width(ROW_AW, COL_AW, TAG_BIT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pass_start,
   input  logic                row_valid,
   input  logic [ROW_AW-1:0]   row_addr,
   input  logic [NUM_COLS-1:0] row_data,
   input  logic                pass_end,
   input  logic [CW-1:0]       ref_char,
   input  logic                clr_mismatch,
   output logic [CW-1:0]       test_char,
   output logic                mismatch,
   output logic                done
);
   if (!rca_pkg::is_pow2(NUM_COLS)) begin : g_bad_cols
      $error("NUM_COLS must be a power of two, at least 2");
   end
   if (ROW_AW < 1) begin : g_bad_row
      $error("ROW_AW must be at least 1");
   end
   if (TAG_BIT != 0 && TAG_BIT != 1) begin : g_bad_tag
      $error("TAG_BIT must be 0 or 1");
   end

   logic [CW-1:0] row_char;
   logic [CW-1:0] acc_next;
   logic          row_parity;

   rca_row_char #(.ROW_AW(ROW_AW), .NUM_COLS(NUM_COLS), .TAG_BIT(TAG_BIT)) u_row (
      .row_addr  (row_addr),
      .row_data  (row_data),
      .row_char  (row_char),
      .row_parity(row_parity)
   );

   rca_accum #(.CW(CW)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pass_start),
      .fold    (row_valid),
      .row_char(row_char),
      .acc     (test_char),
      .acc_next(acc_next)
   );

   rca_pass_check #(.CW(CW)) u_chk (
      .clk         (clk),
      .rst_n       (rst_n),
      .pass_end    (pass_end),
      .clr_mismatch(clr_mismatch),
      .final_char  (acc_next),
      .ref_char    (ref_char),
      .mismatch    (mismatch),
      .done        (done)
   );

   AST_ROW_FIELD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && !(^row_data)) |-> (row_char[COL_AW +: ROW_AW] == '0)); // R3
   AST_ROW_FIELD_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && row_parity) |-> (row_char[COL_AW +: ROW_AW] == row_addr)); // R3
   AST_ZERO_ROW_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      (row_data == '0) |-> (row_char == '0)); // R10
endmodule

// File: tb/refresh_char_acc_test.sv
module refresh_char_acc_test;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_AW = 4;
   localparam int NUM_COLS = 16;
   localparam int COL_AW = 4;
   localparam int CW = 9;
   localparam int NVEC = 8;

   localparam logic [ROW_AW-1:0]   T_ROW  [NVEC] = '{4'd3, 4'd5, 4'd2, 4'd0, 4'd15, 4'd9, 4'd6, 4'd12};
   localparam logic [NUM_COLS-1:0] T_DATA [NVEC] = '{16'h0001, 16'h8000, 16'h0003, 16'h0001,
                                                     16'hFFFF, 16'h0016, 16'h0000, 16'h0421};
   localparam logic [CW-1:0]       T_EXP  [NVEC] = '{9'h130, 9'h15F, 9'h001, 9'h100,
                                                     9'h000, 9'h197, 9'h000, 9'h1CF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pass_start = 1'b0, row_valid = 1'b0, pass_end = 1'b0, clr_mismatch = 1'b0;
   logic [ROW_AW-1:0] row_addr = '0;
   logic [NUM_COLS-1:0] row_data = '0;
   logic [CW-1:0] ref_char = '0;
   logic [CW-1:0] test_char;
   logic mismatch, done;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refresh_char_acc uut (
      .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .row_valid(row_valid),
      .row_addr(row_addr), .row_data(row_data), .pass_end(pass_end),
      .ref_char(ref_char), .clr_mismatch(clr_mismatch),
      .test_char(test_char), .mismatch(mismatch), .done(done)
   );

   // Address-sum model: XOR of {1, row, column} over every 1 bit.
   function automatic logic [CW-1:0] model_char(input logic [ROW_AW-1:0] r, input logic [NUM_COLS-1:0] d);
      logic [CW-1:0] s = '0;
      for (int c = 0; c < NUM_COLS; c++)
         if (d[c]) s ^= {1'b1, r, COL_AW'(c)};
      return s;
   endfunction

   task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, then sample one rising edge later.
   task automatic step(input logic ps, input logic rv, input logic [ROW_AW-1:0] r,
                       input logic [NUM_COLS-1:0] d, input logic pe, input logic [CW-1:0] rc,
                       input logic cm);
      pass_start = ps; row_valid = rv; row_addr = r; row_data = d;
      pass_end = pe; ref_char = rc; clr_mismatch = cm;
      @(negedge clk);
      pass_start = 0; row_valid = 0; pass_end = 0; clr_mismatch = 0;
   endtask

   task automatic idle();
      step(0, 0, '0, '0, 0, '0, 0);
   endtask

   initial begin
      logic [CW-1:0] total;
      logic [CW-1:0] held;
      repeat (3) @(negedge clk);
      check("R1 test_char", test_char, '0);
      check("R1 mismatch", {8'd0, mismatch}, '0);
      check("R1 done", {8'd0, done}, '0);
      rst_n = 1;
      @(negedge clk);

      // Table walk: each vector as its own one-row pass.
      for (int i = 0; i < NVEC; i++) begin
         step(1, 1, T_ROW[i], T_DATA[i], 0, '0, 0);
         check("R2 R3 R4 R6 row char", test_char, T_EXP[i]);
         check("R2 R3 model", test_char, model_char(T_ROW[i], T_DATA[i]));
      end

      // R6: pass_start alone clears
      step(1, 0, '0, '0, 0, '0, 0);
      check("R6 clear", test_char, '0);

      // Full pass accumulating every vector
      total = '0;
      for (int i = 0; i < NVEC; i++) begin
         step(i == 0, 1, T_ROW[i], T_DATA[i], 0, '0, 0);
         total ^= T_EXP[i];
         check("R5 fold", test_char, total);
      end
      idle();
      check("R5 hold", test_char, total);
      step(0, 1, 4'd7, 16'h0000, 0, '0, 0);
      check("R10 zero row", test_char, total);
      step(0, 0, '0, '0, 1, total, 0);
      check("R8 done after end", {8'd0, done}, 9'd1);
      check("R7 match no flag", {8'd0, mismatch}, '0);
      idle();
      check("R8 done one cycle", {8'd0, done}, '0);

      // R7: wrong reference sets mismatch
      held = test_char;
      step(0, 0, '0, '0, 1, held ^ 9'h001, 0);
      check("R7 mismatch set", {8'd0, mismatch}, 9'd1);
      // R9: matching pass keeps it
      step(0, 0, '0, '0, 1, held, 0);
      check("R9 sticky", {8'd0, mismatch}, 9'd1);
      step(0, 0, '0, '0, 0, '0, 1);
      check("R9 cleared", {8'd0, mismatch}, '0);
      step(0, 0, '0, '0, 1, ~held, 1);
      check("R9 set wins", {8'd0, mismatch}, 9'd1);
      step(0, 0, '0, '0, 0, '0, 1);
      check("R9 cleared again", {8'd0, mismatch}, '0);

      // R7: compare includes a row folded in the same cycle
      step(1, 1, 4'd3, 16'h0001, 0, '0, 0);
      step(0, 1, 4'd5, 16'h8000, 1, 9'h130 ^ 9'h15F, 0);
      check("R7 same-cycle row", {8'd0, mismatch}, '0);
      check("R5 value", test_char, 9'h06F);
      step(0, 1, 4'd0, 16'h0001, 1, 9'h06F, 0);
      check("R7 same-cycle row differs", {8'd0, mismatch}, 9'd1);
      check("R4 origin bit", test_char, 9'h16F);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      finished = 1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule